// File: doc/BRIEF.md
# Double-Buffered Parallel Converter Register Front End

This block is the digital side of a 12-bit voltage-output converter. A host writes 12-bit words over a parallel bus. Three active-low strobes qualify each write: a select, a write strobe and a load. A register-select input steers each write to one of two places. One is a data holding register. The other is a small control register that drives the settling-speed, power-down and reference-source controls of the analogue section.

The holding register does not reach the converter by itself. A separate active-low load input copies the holding register into the converter register, which is the code presented to the resistor string. While the load input stays low, the converter register keeps following the holding register. All bus pins are asynchronous to the system clock. They pass through synchronizer chains, and writes are detected on the rising edge of the synchronized write strobe. Data and register-select are taken from a copy delayed by one cycle, which was stable before that edge.

Top module: `dacif_top`

## Requirements
- R1: After reset, dacCode is 0, fast is 0, pd is 0, refInternal is 0 and refHigh is 0.
- R2: A rising edge of weN while csN is low and regSel is 0 stores dataIn into the holding register, and dacCode does not change while ldN is high.
- R3: A rising edge of weN while csN is high changes neither the holding register nor the control register.
- R4: Driving ldN low copies the holding register into dacCode.
- R5: While ldN is held low, dacCode follows every later write to the holding register.
- R6: A control write (regSel = 1) sets fast from data bit 0, where 1 means fast settling.
- R7: A control write sets pd from data bit 1, where 1 means powered down.
- R8: Data bits 3:2 of a control write select the reference: 00 gives refInternal=0, refHigh=0; 01 gives refInternal=1, refHigh=0; 10 gives refInternal=1, refHigh=1; 11 gives refInternal=0, refHigh=0.
- R9: Data bits 11:4 of a control write have no effect on any output.
- R10: A control write changes neither dacCode nor the holding register.
- R11: Entering power-down and then leaving it keeps dacCode at the value it had before power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select, asynchronous |
| weN | input | 1 | Active-low write strobe; write on its rising edge |
| ldN | input | 1 | Active-low load of the converter register |
| regSel | input | 1 | 0 = holding register, 1 = control register |
| dataIn | input | DATA_W | Parallel write data |
| dacCode | output | DATA_W | Converter register contents |
| fast | output | 1 | Fast settling select |
| pd | output | 1 | Power-down flag |
| refInternal | output | 1 | Internal reference selected |
| refHigh | output | 1 | Internal reference at the high level |

## Verification
The bench builds the block with its default parameters: a 12-bit data path and two-stage synchronizers. The full width lets the tests use codes with scattered upper bits, so a lost or shifted bit shows up at the output. It also fills control bits 11:4 with ones, which tests that those bits are ignored. With two sync stages, each strobe edge takes a few cycles to act. The tests hold every strobe level long enough to cover that delay. They also keep ldN low across several writes, to test that dacCode follows the holding register.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int CTRL_W  = 4;
  localparam int FAST_BIT = 0;
  localparam int PD_BIT   = 1;
  localparam int REF_LSB  = 2;

  typedef struct packed {
    logic wrHold;
    logic wrCtrl;
    logic load;
  } dacStrobeT;

  typedef enum logic [1:0] {
    REF_EXT_A  = 2'b00,
    REF_INT_LO = 2'b01,
    REF_INT_HI = 2'b10,
    REF_EXT_B  = 2'b11
  } refSelT;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= {WIDTH{RESET_VAL}};
    else       stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[i] <= {WIDTH{RESET_VAL}};
      else       stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dacif_ctrl.sv
module dacif_ctrl
  import dacif_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              weN,
  input  logic              ldN,
  input  logic              regSel,
  input  logic [DATA_W-1:0] dataIn,
  output dacStrobeT         strb,
  output logic [DATA_W-1:0] wrData
);
  localparam int BUS_W = DATA_W + 1;

  logic [2:0]       pinSync;
  logic [BUS_W-1:0] busSync;
  logic [BUS_W-1:0] busDly;
  logic             weDly;
  logic             csDly;
  logic             weRise;
  logic             wrAny;

  dacif_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uPinSync (
    .clk(clk), .rstN(rstN), .d({csN, weN, ldN}), .q(pinSync)
  );

  dacif_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uBusSync (
    .clk(clk), .rstN(rstN), .d({regSel, dataIn}), .q(busSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weDly  <= 1'b1;
      csDly  <= 1'b1;
      busDly <= '0;
    end else begin
      weDly  <= pinSync[1];
      csDly  <= pinSync[2];
      busDly <= busSync;
    end
  end

  always_comb begin
    weRise      = pinSync[1] & ~weDly;
    wrAny       = weRise & ~csDly;
    strb.wrHold = wrAny & ~busDly[DATA_W];
    strb.wrCtrl = wrAny &  busDly[DATA_W];
    strb.load   = ~pinSync[0];
    wrData      = busDly[DATA_W-1:0];
  end
endmodule

// File: rtl/dacif_datapath.sv
module dacif_datapath
  import dacif_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dacStrobeT         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] holdCode,
  output logic [DATA_W-1:0] dacCode,
  output logic              fast,
  output logic              pd,
  output logic              refInternal,
  output logic              refHigh
);
  logic [CTRL_W-1:0] ctrlQ;
  refSelT            refSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdCode <= '0;
    else if (strb.wrHold) holdCode <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dacCode <= '0;
    else if (strb.load) dacCode <= holdCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else if (strb.wrCtrl) ctrlQ <= wrData[CTRL_W-1:0];
  end

  always_comb begin
    refSel      = refSelT'(ctrlQ[REF_LSB+1:REF_LSB]);
    fast        = ctrlQ[FAST_BIT];
    pd          = ctrlQ[PD_BIT];
    refInternal = (refSel == REF_INT_LO) || (refSel == REF_INT_HI);
    refHigh     = (refSel == REF_INT_HI);
  end
endmodule

// File: rtl/dacif_top.sv
module dacif_top
  import dacif_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              weN,
  input  logic              ldN,
  input  logic              regSel,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dacCode,
  output logic              fast,
  output logic              pd,
  output logic              refInternal,
  output logic              refHigh
);
  dacStrobeT         strb;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] holdCode;

  dacif_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .ldN(ldN),
    .regSel(regSel), .dataIn(dataIn), .strb(strb), .wrData(wrData)
  );

  dacif_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .holdCode(holdCode), .dacCode(dacCode), .fast(fast), .pd(pd),
    .refInternal(refInternal), .refHigh(refHigh)
  );
endmodule

// File: rtl/dacif_chk.sv
module dacif_chk
  import dacif_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input dacStrobeT         strb,
  input logic [DATA_W-1:0] holdCode,
  input logic [DATA_W-1:0] dacCode,
  input logic              fast,
  input logic              pd,
  input logic              refInternal,
  input logic              refHigh
);
  AST_RESET_STATE: assert property (@(posedge clk)
    $rose(rstN) |-> (dacCode == '0) && !pd && !fast && !refInternal); // R1

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrHold && strb.wrCtrl)); // R2

  AST_NO_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(dacCode)); // R2

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (dacCode == $past(holdCode))); // R4

  AST_CTRL_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCtrl |=> $stable(holdCode)); // R10

  AST_REF_HIGH_INTERNAL: assert property (@(posedge clk) disable iff (!rstN)
    refHigh |-> refInternal); // R8

  AST_PD_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pd) || $fell(pd)) && !$past(strb.load) |-> $stable(dacCode)); // R11
endmodule

bind dacif_top dacif_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .holdCode(holdCode),
  .dacCode(dacCode), .fast(fast), .pd(pd),
  .refInternal(refInternal), .refHigh(refHigh)
);

// File: tb/sim_dacif_top.sv
module sim_dacif_top;
  localparam int DATA_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic weN = 1'b1;
  logic ldN = 1'b1;
  logic regSel = 1'b0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] dacCode;
  logic fast, pd, refInternal, refHigh;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dacif_top #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .ldN(ldN),
    .regSel(regSel), .dataIn(dataIn), .dacCode(dacCode), .fast(fast),
    .pd(pd), .refInternal(refInternal), .refHigh(refHigh)
  );

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic sel, input logic [DATA_W-1:0] d, input logic cs);
    csN = cs; regSel = sel; dataIn = d;
    waitClk(4);
    weN = 1'b0; waitClk(4);
    weN = 1'b1; waitClk(4);
    csN = 1'b1; waitClk(4);
  endtask

  task automatic pulseLoad();
    ldN = 1'b0; waitClk(5);
    ldN = 1'b1; waitClk(5);
  endtask

  task automatic tReset();
    check("R1 dacCode", int'(dacCode), 0);
    check("R1 fast", int'(fast), 0);
    check("R1 pd", int'(pd), 0);
    check("R1 refInternal", int'(refInternal), 0);
    check("R1 refHigh", int'(refHigh), 0);
  endtask

  task automatic tHoldThenLoad();
    busWrite(1'b0, 12'hA5C, 1'b0);
    check("R2 no load yet", int'(dacCode), 0);
    pulseLoad();
    check("R4 load copies", int'(dacCode), 12'hA5C);
  endtask

  task automatic tSelectHigh();
    busWrite(1'b0, 12'h123, 1'b1);
    pulseLoad();
    check("R3 hold ignored", int'(dacCode), 12'hA5C);
    busWrite(1'b1, 12'h00B, 1'b1);
    check("R3 ctrl fast ignored", int'(fast), 0);
    check("R3 ctrl pd ignored", int'(pd), 0);
    check("R3 ctrl ref ignored", int'(refInternal), 0);
  endtask

  task automatic tControl();
    busWrite(1'b1, 12'h001, 1'b0);
    check("R6 fast set", int'(fast), 1);
    check("R7 pd clear", int'(pd), 0);
    check("R10 dacCode kept", int'(dacCode), 12'hA5C);
    pulseLoad();
    check("R10 hold kept", int'(dacCode), 12'hA5C);
    busWrite(1'b1, 12'h000, 1'b0);
    check("R6 fast clear", int'(fast), 0);
  endtask

  task automatic tReference();
    for (int code = 0; code < 4; code++) begin
      busWrite(1'b1, 12'hFF0 | DATA_W'(code << 2), 1'b0);
      check("R8 refInternal", int'(refInternal), (code == 1 || code == 2) ? 1 : 0);
      check("R8 refHigh", int'(refHigh), (code == 2) ? 1 : 0);
      check("R9 fast untouched", int'(fast), 0);
      check("R9 pd untouched", int'(pd), 0);
      check("R9 dacCode untouched", int'(dacCode), 12'hA5C);
    end
    busWrite(1'b1, 12'h000, 1'b0);
  endtask

  task automatic tFollow();
    ldN = 1'b0;
    busWrite(1'b0, 12'h3C7, 1'b0);
    check("R5 follows first", int'(dacCode), 12'h3C7);
    busWrite(1'b0, 12'h801, 1'b0);
    check("R5 follows second", int'(dacCode), 12'h801);
    ldN = 1'b1; waitClk(5);
    busWrite(1'b0, 12'h555, 1'b0);
    check("R2 held after release", int'(dacCode), 12'h801);
  endtask

  task automatic tPowerDown();
    busWrite(1'b0, 12'h7E1, 1'b0);
    pulseLoad();
    busWrite(1'b1, 12'h002, 1'b0);
    check("R7 pd set", int'(pd), 1);
    check("R11 code in pd", int'(dacCode), 12'h7E1);
    busWrite(1'b1, 12'h000, 1'b0);
    check("R7 pd released", int'(pd), 0);
    check("R11 code restored", int'(dacCode), 12'h7E1);
  endtask

  initial begin
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    tReset();
    tHoldThenLoad();
    tSelectHigh();
    tControl();
    tReference();
    tFollow();
    tPowerDown();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    waitClk(100000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule